// File: doc/BRIEF.md
# HDLC Interrupt Flag Controller

This block keeps the interrupt request state of one HDLC serial channel. It has four request flags: special receive, external/status, receive and transmit. It also has a CRC error flag of its own. The HDLC engine sends single-cycle event pulses that set these flags. Software clears them by writing ones to an 8-bit control register. A write of zero to any bit has no effect.

The external/status request also acts as a latch. The first event captures a cause code. Later events are ignored until software clears the request, and that clear re-arms the latch.

The transmit request is raised at the close of a frame, and its timing depends on one condition. If no data went into the transmit queue while the closing CRC bytes were being sent, the request is raised as soon as the second CRC byte finishes. If data did go in, the block waits until the queue level drains back to the threshold. The combined interrupt line is the OR of the four request flags.

Top module: `hdlc_irq_ctrl`

## Requirements
- R1: Writing control bit 7 clears the special receive request. Bit 6 clears the external/status request, bit 2 clears the CRC error flag, bit 1 clears the receive request and bit 0 clears the transmit request. Each flag is low in the cycle after the write.
- R2: A write with a bit at 0 leaves the corresponding flag unchanged.
- R3: Clearing the special receive request (bit 7 alone) leaves the CRC error flag unchanged.
- R4: An external/status event while that request is clear sets the request and captures `es_cause_i` into `es_cause_o`. Both are visible in the cycle after the event.
- R5: While the external/status request is set, further external/status events do not change `es_cause_o`.
- R6: Clearing the external/status request re-arms the latch, so a later event sets the request again with its new cause.
- R7: The refill window opens on `ev_crc_start_i` and closes on `ev_crc2_done_i`. If `txq_wr_i` was not seen inside the window, the transmit request is set in the cycle after `ev_crc2_done_i`.
- R8: If `txq_wr_i` was seen inside the window, the transmit request is not set on `ev_crc2_done_i`. It is set one cycle after the first cycle that follows the pulse in which `txq_level_i <= txq_thresh_i`.
- R9: `irq_o` is high exactly when at least one of the four request flags is high.
- R10: An event pulse in the same cycle as a clear write for that flag leaves the flag set.
- R11: Reset clears all flags, the captured cause and the transmit wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_sp_i | input | 1 | Special receive event pulse |
| ev_crc_err_i | input | 1 | CRC error event pulse |
| ev_es_i | input | 1 | External/status event pulse |
| es_cause_i | input | CAUSE_W | Cause code accompanying `ev_es_i` |
| ev_rx_i | input | 1 | Receive event pulse |
| ev_crc_start_i | input | 1 | Closing CRC of a frame begins |
| ev_crc2_done_i | input | 1 | Second CRC byte has been sent |
| txq_wr_i | input | 1 | Data written into the transmit queue |
| txq_level_i | input | LVL_W | Transmit queue fill level |
| txq_thresh_i | input | LVL_W | Transmit queue threshold |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | REG_W | Control register write data |
| sp_req_o | output | 1 | Special receive request flag |
| es_req_o | output | 1 | External/status request flag (latch held) |
| rx_req_o | output | 1 | Receive request flag |
| tx_req_o | output | 1 | Transmit request flag |
| crc_err_o | output | 1 | CRC error flag |
| es_cause_o | output | CAUSE_W | Latched external/status cause |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Most faults in this block are stuck or wrongly held flag bits. Those show on the flag outputs and on `irq_o` one cycle after the event or write involved. A latch that fails to hold shows the same way: `es_cause_o` changes on the cycle after a second event. The transmit path keeps hidden state, namely the window, the refill mark and the wait state. A fault there shows as a transmit request that comes one cycle too early or late, or never comes, and it appears only at the close of a frame. For that reason the directed tests sample `tx_req_o` in each cycle around `ev_crc2_done_i` and around the drop in queue level.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
  // Control register bit positions (the write-1-to-clear layout software uses)
  localparam int unsigned CLR_SP_BIT  = 7;
  localparam int unsigned CLR_ES_BIT  = 6;
  localparam int unsigned CLR_CRC_BIT = 2;
  localparam int unsigned CLR_RX_BIT  = 1;
  localparam int unsigned CLR_TX_BIT  = 0;

  // Index of each simple flag inside the shared flag vector
  localparam int unsigned FL_SP  = 0;
  localparam int unsigned FL_CRC = 1;
  localparam int unsigned FL_RX  = 2;
  localparam int unsigned FL_TX  = 3;
  localparam int unsigned FL_NUM = 4;

  typedef enum logic {
    TXW_IDLE = 1'b0,
    TXW_WAIT = 1'b1
  } txw_state_e;
endpackage

// File: rtl/hdlc_irq_flag.sv
module hdlc_irq_flag #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_nxt;

  // A set pulse wins over a clear in the same cycle
  always_comb begin
    for (int i = 0; i < N; i++) begin
      q_nxt[i] = set_i[i] | (q_o[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end
endmodule

// File: rtl/hdlc_irq_es_latch.sv
module hdlc_irq_es_latch #(
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               release_i,
  output logic               held_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               held_nxt;
  logic               capture;
  logic [CAUSE_W-1:0] cause_nxt;

  // An event is accepted when the latch is free or being released this cycle
  always_comb begin
    capture   = ev_i & (~held_o | release_i);
    held_nxt  = capture | (held_o & ~release_i);
    cause_nxt = capture ? cause_i : cause_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o  <= 1'b0;
      cause_o <= '0;
    end else begin
      held_o <= held_nxt;
      if (capture) cause_o <= cause_nxt;
    end
  end
endmodule

// File: rtl/hdlc_irq_tx_timer.sv
module hdlc_irq_tx_timer
  import hdlc_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_start_i,
  input  logic             crc2_done_i,
  input  logic             txq_wr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             tx_set_o
);
  logic       win_q, win_nxt;
  logic       refill_q, refill_nxt;
  txw_state_e st_q, st_nxt;
  logic       drained;

  always_comb begin
    drained = (level_i <= thresh_i);

    win_nxt = win_q;
    if (crc_start_i)      win_nxt = 1'b1;
    else if (crc2_done_i) win_nxt = 1'b0;

    refill_nxt = refill_q;
    if (crc_start_i || crc2_done_i) refill_nxt = 1'b0;
    else if (win_q && txq_wr_i)     refill_nxt = 1'b1;

    st_nxt   = st_q;
    tx_set_o = 1'b0;
    if (crc2_done_i && !refill_q) begin
      tx_set_o = 1'b1;
    end
    if (st_q == TXW_WAIT && drained) begin
      tx_set_o = 1'b1;
      st_nxt   = TXW_IDLE;
    end
    if (crc2_done_i && refill_q) st_nxt = TXW_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= 1'b0;
      refill_q <= 1'b0;
      st_q     <= TXW_IDLE;
    end else begin
      win_q    <= win_nxt;
      refill_q <= refill_nxt;
      st_q     <= st_nxt;
    end
  end
endmodule

// File: rtl/hdlc_irq_ctrl.sv
module hdlc_irq_ctrl
  import hdlc_irq_pkg::*;
#(
  parameter int unsigned CAUSE_W = 4,
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned REG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_sp_i,
  input  logic               ev_crc_err_i,
  input  logic               ev_es_i,
  input  logic [CAUSE_W-1:0] es_cause_i,
  input  logic               ev_rx_i,
  input  logic               ev_crc_start_i,
  input  logic               ev_crc2_done_i,
  input  logic               txq_wr_i,
  input  logic [LVL_W-1:0]   txq_level_i,
  input  logic [LVL_W-1:0]   txq_thresh_i,
  input  logic               reg_wr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic               sp_req_o,
  output logic               es_req_o,
  output logic               rx_req_o,
  output logic               tx_req_o,
  output logic               crc_err_o,
  output logic [CAUSE_W-1:0] es_cause_o,
  output logic               irq_o
);
  logic [REG_W-1:0]  clr_bits;
  logic [FL_NUM-1:0] fl_set, fl_clr, fl_q;
  logic              tx_set;

  always_comb begin
    clr_bits        = reg_wr_i ? reg_wdata_i : '0;
    fl_set          = '0;
    fl_clr          = '0;
    fl_set[FL_SP]   = ev_sp_i;
    fl_set[FL_CRC]  = ev_crc_err_i;
    fl_set[FL_RX]   = ev_rx_i;
    fl_set[FL_TX]   = tx_set;
    fl_clr[FL_SP]   = clr_bits[CLR_SP_BIT];
    fl_clr[FL_CRC]  = clr_bits[CLR_CRC_BIT];
    fl_clr[FL_RX]   = clr_bits[CLR_RX_BIT];
    fl_clr[FL_TX]   = clr_bits[CLR_TX_BIT];
  end

  hdlc_irq_flag #(.N(FL_NUM)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fl_set),
    .clr_i (fl_clr),
    .q_o   (fl_q)
  );

  hdlc_irq_es_latch #(.CAUSE_W(CAUSE_W)) u_es (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev_es_i),
    .cause_i   (es_cause_i),
    .release_i (clr_bits[CLR_ES_BIT]),
    .held_o    (es_req_o),
    .cause_o   (es_cause_o)
  );

  hdlc_irq_tx_timer #(.LVL_W(LVL_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .crc_start_i (ev_crc_start_i),
    .crc2_done_i (ev_crc2_done_i),
    .txq_wr_i    (txq_wr_i),
    .level_i     (txq_level_i),
    .thresh_i    (txq_thresh_i),
    .tx_set_o    (tx_set)
  );

  always_comb begin
    sp_req_o  = fl_q[FL_SP];
    crc_err_o = fl_q[FL_CRC];
    rx_req_o  = fl_q[FL_RX];
    tx_req_o  = fl_q[FL_TX];
    irq_o     = sp_req_o | es_req_o | rx_req_o | tx_req_o;
  end
endmodule

// File: rtl/hdlc_irq_ctrl_chk.sv
module hdlc_irq_ctrl_chk #(
  parameter int unsigned CAUSE_W = 4,
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned REG_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_sp_i,
  input logic               ev_crc_err_i,
  input logic               ev_es_i,
  input logic               ev_rx_i,
  input logic               reg_wr_i,
  input logic [REG_W-1:0]   reg_wdata_i,
  input logic               sp_req_o,
  input logic               es_req_o,
  input logic               rx_req_o,
  input logic               crc_err_o,
  input logic [CAUSE_W-1:0] es_cause_o
);
  AST_CLR_RX_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && reg_wdata_i[1] && !ev_rx_i |=> !rx_req_o); // R1

  AST_CLR_SP_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && reg_wdata_i[7] && !ev_sp_i |=> !sp_req_o); // R1

  AST_ZERO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && reg_wdata_i == '0 && rx_req_o |=> rx_req_o); // R2

  AST_CRC_SURVIVES_SP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_o && !(reg_wr_i && reg_wdata_i[2]) |=> crc_err_o); // R3

  AST_ES_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    es_req_o && !(reg_wr_i && reg_wdata_i[6]) |=> es_req_o && $stable(es_cause_o)); // R5

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_i && reg_wr_i && reg_wdata_i[1] |=> rx_req_o); // R10
endmodule

bind hdlc_irq_ctrl hdlc_irq_ctrl_chk #(
  .CAUSE_W(CAUSE_W),
  .LVL_W  (LVL_W),
  .REG_W  (REG_W)
) u_chk (.*);

// File: tb/hdlc_irq_ctrl_tb_top.sv
module hdlc_irq_ctrl_tb_top;
  localparam int unsigned CAUSE_W = 4;
  localparam int unsigned LVL_W   = 5;
  localparam int unsigned REG_W   = 8;

  logic               clk;
  logic               rst_n;
  logic               ev_sp_i, ev_crc_err_i, ev_es_i, ev_rx_i;
  logic [CAUSE_W-1:0] es_cause_i;
  logic               ev_crc_start_i, ev_crc2_done_i, txq_wr_i;
  logic [LVL_W-1:0]   txq_level_i, txq_thresh_i;
  logic               reg_wr_i;
  logic [REG_W-1:0]   reg_wdata_i;
  logic               sp_req_o, es_req_o, rx_req_o, tx_req_o, crc_err_o, irq_o;
  logic [CAUSE_W-1:0] es_cause_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  hdlc_irq_ctrl #(.CAUSE_W(CAUSE_W), .LVL_W(LVL_W), .REG_W(REG_W)) dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_sp_i = 0; ev_crc_err_i = 0; ev_es_i = 0; ev_rx_i = 0;
    ev_crc_start_i = 0; ev_crc2_done_i = 0; txq_wr_i = 0;
    reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(input logic [REG_W-1:0] d);
    reg_wr_i = 1; reg_wdata_i = d;
    step();
  endtask

  task automatic t_reset();
    idle_inputs();
    es_cause_i = '0; txq_level_i = '0; txq_thresh_i = 5'd4;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset flags", {sp_req_o, es_req_o, rx_req_o, tx_req_o, crc_err_o}, 0);
    chk("R11 reset cause", es_cause_o, 0);
    chk("R9 irq idle", irq_o, 0);
  endtask

  task automatic t_clear_bits();
    ev_sp_i = 1; ev_rx_i = 1; ev_crc_err_i = 1; ev_es_i = 1; es_cause_i = 4'h3;
    step();
    chk("R9 irq set", irq_o, 1);
    wr(8'h7D); // every bit except 7 and 1
    chk("R2 zero bit keeps sp", sp_req_o, 1);
    chk("R2 zero bit keeps rx", rx_req_o, 1);
    chk("R1 bit6 clears es", es_req_o, 0);
    chk("R1 bit2 clears crc", crc_err_o, 0);
    wr(8'h80);
    chk("R1 bit7 clears sp", sp_req_o, 0);
    wr(8'h02);
    chk("R1 bit1 clears rx", rx_req_o, 0);
    chk("R9 irq clear", irq_o, 0);
  endtask

  task automatic t_crc_keep();
    ev_sp_i = 1; ev_crc_err_i = 1;
    step();
    wr(8'h80);
    chk("R3 sp cleared", sp_req_o, 0);
    chk("R3 crc kept", crc_err_o, 1);
    wr(8'h00);
    chk("R2 zero write crc kept", crc_err_o, 1);
    wr(8'h04);
    chk("R1 crc cleared", crc_err_o, 0);
  endtask

  task automatic t_es_latch();
    ev_es_i = 1; es_cause_i = 4'h5;
    step();
    chk("R4 es set", es_req_o, 1);
    chk("R4 cause", es_cause_o, 5);
    ev_es_i = 1; es_cause_i = 4'hA;
    step();
    chk("R5 cause held", es_cause_o, 5);
    wr(8'h40);
    chk("R6 es released", es_req_o, 0);
    ev_es_i = 1; es_cause_i = 4'hC;
    step();
    chk("R6 es re-armed", es_req_o, 1);
    chk("R6 new cause", es_cause_o, 12);
    wr(8'h40);
  endtask

  task automatic t_tx_immediate();
    txq_wr_i = 1; // outside the window: must not count
    step();
    ev_crc_start_i = 1;
    step();
    step();
    chk("R7 no early tx", tx_req_o, 0);
    ev_crc2_done_i = 1;
    step();
    chk("R7 immediate tx", tx_req_o, 1);
    chk("R9 irq tx", irq_o, 1);
    wr(8'h01);
    chk("R1 bit0 clears tx", tx_req_o, 0);
  endtask

  task automatic t_tx_deferred();
    txq_level_i = 5'd10;
    ev_crc_start_i = 1;
    step();
    txq_wr_i = 1;
    step();
    ev_crc2_done_i = 1;
    step();
    chk("R8 not at crc2", tx_req_o, 0);
    step();
    chk("R8 waiting above threshold", tx_req_o, 0);
    txq_level_i = 5'd4;
    @(negedge clk);
    chk("R8 tx at threshold", tx_req_o, 1);
    wr(8'h01);
    chk("R8 single shot", tx_req_o, 0);
    step();
    chk("R8 stays clear", tx_req_o, 0);
  endtask

  task automatic t_collision();
    ev_rx_i = 1;
    step();
    ev_rx_i = 1; reg_wr_i = 1; reg_wdata_i = 8'h02;
    step();
    chk("R10 event beats clear", rx_req_o, 1);
    wr(8'h02);
    chk("R10 later clear", rx_req_o, 0);
  endtask

  initial begin
    rst_n = 0;
    t_reset();
    t_clear_bits();
    t_crc_keep();
    t_es_latch();
    t_tx_immediate();
    t_tx_deferred();
    t_collision();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R11 actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule